// File: doc/BRIEF.md
# Debug Register Access Gate

This block sits behind an APB slave port in front of a small bank of debug registers. On every transfer it decides whether the access takes effect, is quietly discarded, or ends with an error response. The decision depends on four things: where the access came from, the state of a software write lock, the state of an operating-system save/restore lock, and the power state of the core. The core power state is the live power-down request plus a sticky record of any past power-down. The gate owns both locks and the sticky bit. It answers every transfer with zero wait states and raises a one-hot write enable for the register class that an accepted write targets.

The top address bit marks an access from an external debugger, and such an access is never stopped by the software lock. Core-domain registers give an error response while the core is down, while the sticky power-down bit is set, or while the OS lock is held. Identification, event-catch, run-control, power-management and management-space registers always complete normally. The sticky bit is cleared when its status register is read. Software cannot clear it this way while the software lock is held.

Top module: `dbg_access_gate`

## Requirements
- R1: `pready` is 1 in every access phase (`psel` and `penable` both high) and 0 at all other times.
- R2: An access with `paddr[31]`=1 ignores the software lock: its writes take effect as if the lock were clear.
- R3: While the software lock is set, a write with `paddr[31]`=0 to any register other than the lock-key register (offset 0xFB0) is dropped with `pslverr`=0, and raises no write enable. Reads still return data.
- R4: A write to offset 0xFB0 is always accepted. Data 0xC5ACCE55 clears the software lock and any other value sets it. Offset 0xFB4 reads bit0=1 and bit1=software lock.
- R5: A write to offset 0x300 with 0xC5ACCE55 sets the OS lock, and any other value clears it. Offset 0x304 reads bit0=1 and bit1=OS lock.
- R6: The core region is word offsets 0x0A0–0x7FC, excluding 0x300–0x314. An access there returns `pslverr`=1 and `prdata`=0, and discards its write, whenever the power-down request, the sticky bit or the OS lock is 1. The first 4 words from 0x0A0 are read/write storage; the rest of the region reads 0.
- R7: Offsets 0x000 (ID, reads the DIDR_VALUE parameter), 0x01C (event catch), 0x090 (run control, reads 0), 0x300–0x314 and 0xF00–0xFFC never return `pslverr`.
- R8: Every clock edge with `core_pwrdn_req`=1 sets the sticky bit. Offset 0x314 reads bit1=sticky and bit0=`core_pwrdn_req`. A read of 0x314 clears the sticky bit at the end of the transfer unless `core_pwrdn_req` is 1.
- R9: A read of 0x314 with `paddr[31]`=0 while the software lock is set returns the status but leaves the sticky bit set.
- R10: `reg_wr_en` is one-hot or zero and pulses only in the access phase of an accepted write. The bit positions are: bit0 event catch (0x01C), bit1 run control (0x090), bit2 core region, bit3 power-down control (0x310), bit4 management space other than 0xFB0/0xFB4.
- R11: After reset the software lock reads 1, and the OS lock, the sticky bit, the event-catch register, the power-down control register and the core storage all read 0.
- R12: Offsets outside every range above read 0 without error, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the debug power domain |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write |
| paddr | input | 32 | APB address; bit 31 marks an external-debugger access, bits 11:2 the word offset |
| pwdata | input | 32 | APB write data |
| core_pwrdn_req | input | 1 | Core power-down request |
| prdata | output | 32 | APB read data, 0 on error or write |
| pready | output | 1 | APB ready |
| pslverr | output | 1 | APB error response |
| reg_wr_en | output | 5 | Per-class write enables |

## Verification
The assertions assume the APB protocol is followed. Every access phase comes right after a one-cycle setup phase with the same address, direction and data, and `core_pwrdn_req` changes only between transfers. The driver task always issues setup then access, and changes `core_pwrdn_req` only while the bus is idle. It also holds the request long enough for a clock edge to latch the sticky bit before the next transfer begins. Under these conditions the monitor can compare each access phase against one expected item.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;

    localparam int          DW         = 32;
    localparam int          WORD_W     = 10;
    localparam logic [DW-1:0] UNLOCK_KEY = 32'hC5AC_CE55;

    // write-enable bit positions
    localparam int WE_ECR  = 0;
    localparam int WE_DRCR = 1;
    localparam int WE_CORE = 2;
    localparam int WE_PRCR = 3;
    localparam int WE_MGMT = 4;
    localparam int NUM_WE  = 5;

    // word offsets (byte offset >> 2)
    localparam logic [WORD_W-1:0] W_ID      = 10'h000;
    localparam logic [WORD_W-1:0] W_ECR     = 10'h007;
    localparam logic [WORD_W-1:0] W_DRCR    = 10'h024;
    localparam logic [WORD_W-1:0] W_CORE_LO = 10'h028;
    localparam logic [WORD_W-1:0] W_CORE_HI = 10'h1FF;
    localparam logic [WORD_W-1:0] W_OSKEY   = 10'h0C0;
    localparam logic [WORD_W-1:0] W_OSSTAT  = 10'h0C1;
    localparam logic [WORD_W-1:0] W_PM_HI   = 10'h0C5;
    localparam logic [WORD_W-1:0] W_PDCTL   = 10'h0C4;
    localparam logic [WORD_W-1:0] W_PDSTAT  = 10'h0C5;
    localparam logic [WORD_W-1:0] W_MGMT_LO = 10'h3C0;
    localparam logic [WORD_W-1:0] W_SWKEY   = 10'h3EC;
    localparam logic [WORD_W-1:0] W_SWSTAT  = 10'h3ED;

    typedef enum logic [3:0] {
        RG_ID, RG_ECR, RG_DRCR, RG_CORE, RG_OSKEY, RG_OSSTAT,
        RG_PDCTL, RG_PDSTAT, RG_SWKEY, RG_SWSTAT, RG_MGMT, RG_NONE
    } region_e;

    typedef struct packed {
        logic              access;   // access phase
        logic              wr;       // access phase write
        logic              rd;       // access phase read
        logic              err;      // error response
        logic              wr_ok;    // write takes effect
        logic              rd_quiet; // read must not change state
        region_e           region;
        logic [WORD_W-1:0] word;
    } verdict_t;

    function automatic region_e classify(input logic [WORD_W-1:0] w);
        region_e r;
        if (w == W_ID)                          r = RG_ID;
        else if (w == W_ECR)                    r = RG_ECR;
        else if (w == W_DRCR)                   r = RG_DRCR;
        else if (w == W_OSKEY)                  r = RG_OSKEY;
        else if (w == W_OSSTAT)                 r = RG_OSSTAT;
        else if (w == W_PDCTL)                  r = RG_PDCTL;
        else if (w == W_PDSTAT)                 r = RG_PDSTAT;
        else if (w > W_OSSTAT && w < W_PM_HI)   r = RG_NONE;
        else if (w >= W_CORE_LO && w <= W_CORE_HI) r = RG_CORE;
        else if (w == W_SWKEY)                  r = RG_SWKEY;
        else if (w == W_SWSTAT)                 r = RG_SWSTAT;
        else if (w >= W_MGMT_LO)                r = RG_MGMT;
        else                                    r = RG_NONE;
        return r;
    endfunction

endpackage

// File: rtl/dbg_gate_decode.sv
module dbg_gate_decode
    import dbg_gate_pkg::*;
(
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [DW-1:0] paddr,
    input  logic          swlock,
    input  logic          oslock,
    input  logic          sticky,
    input  logic          core_pwrdn_req,
    output verdict_t      v
);

    logic    ext;
    logic    blocked;
    logic    dropped;
    region_e reg_sel;

    always_comb begin
        ext     = paddr[DW-1];
        reg_sel = classify(paddr[WORD_W+1:2]);
        blocked = (reg_sel == RG_CORE) && (core_pwrdn_req || sticky || oslock);
        dropped = !ext && swlock && (reg_sel != RG_SWKEY);

        v.access   = psel && penable;
        v.wr       = v.access && pwrite;
        v.rd       = v.access && !pwrite;
        v.err      = v.access && blocked;
        v.wr_ok    = v.wr && !blocked && !dropped;
        v.rd_quiet = !ext && swlock;
        v.region   = reg_sel;
        v.word     = paddr[WORD_W+1:2];
    end

endmodule

// File: rtl/dbg_gate_state.sv
module dbg_gate_state
    import dbg_gate_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  verdict_t      v,
    input  logic [DW-1:0] pwdata,
    input  logic          core_pwrdn_req,
    output logic          swlock,
    output logic          oslock,
    output logic          sticky
);

    logic sw_key_wr;
    logic os_key_wr;
    logic sticky_clr;

    always_comb begin
        sw_key_wr  = v.wr_ok && (v.region == RG_SWKEY);
        os_key_wr  = v.wr_ok && (v.region == RG_OSKEY);
        sticky_clr = v.rd && (v.region == RG_PDSTAT) && !v.rd_quiet;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            swlock <= 1'b1;
            oslock <= 1'b0;
            sticky <= 1'b0;
        end else begin
            if (sw_key_wr) swlock <= (pwdata != UNLOCK_KEY);
            if (os_key_wr) oslock <= (pwdata == UNLOCK_KEY);
            if (core_pwrdn_req)  sticky <= 1'b1;
            else if (sticky_clr) sticky <= 1'b0;
        end
    end

    // R8
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        core_pwrdn_req |=> sticky);

    // R4
    sw_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (v.wr && v.region == RG_SWKEY && pwdata == UNLOCK_KEY) |=> !swlock);

    // R9
    quiet_read_chk: assert property (@(posedge clk) disable iff (rst)
        (v.rd && v.rd_quiet && sticky) |=> sticky);

endmodule

// File: rtl/dbg_gate_regs.sv
module dbg_gate_regs
    import dbg_gate_pkg::*;
#(
    parameter logic [31:0] DIDR_VALUE = 32'h1510_0001,
    parameter int          ECR_W      = 8,
    parameter int          CORE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  verdict_t          v,
    input  logic [DW-1:0]     pwdata,
    input  logic              core_pwrdn_req,
    input  logic              swlock,
    input  logic              oslock,
    input  logic              sticky,
    output logic [DW-1:0]     prdata,
    output logic [NUM_WE-1:0] reg_wr_en
);

    localparam int PDCTL_W = 2;

    logic [ECR_W-1:0]   ecr_q;
    logic [PDCTL_W-1:0] pdctl_q;
    logic [DW-1:0]      core_q [CORE_WORDS];
    logic [DW-1:0]      core_rd;
    logic [DW-1:0]      mux;

    always_comb begin
        reg_wr_en          = '0;
        reg_wr_en[WE_ECR]  = v.wr_ok && (v.region == RG_ECR);
        reg_wr_en[WE_DRCR] = v.wr_ok && (v.region == RG_DRCR);
        reg_wr_en[WE_CORE] = v.wr_ok && (v.region == RG_CORE);
        reg_wr_en[WE_PRCR] = v.wr_ok && (v.region == RG_PDCTL);
        reg_wr_en[WE_MGMT] = v.wr_ok && (v.region == RG_MGMT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ecr_q   <= '0;
            pdctl_q <= '0;
        end else begin
            if (reg_wr_en[WE_ECR])  ecr_q   <= pwdata[ECR_W-1:0];
            if (reg_wr_en[WE_PRCR]) pdctl_q <= pwdata[PDCTL_W-1:0];
        end
    end

    for (genvar i = 0; i < CORE_WORDS; i++) begin : g_core
        localparam logic [WORD_W-1:0] ADDR = W_CORE_LO + WORD_W'(i);
        always_ff @(posedge clk) begin
            if (rst)
                core_q[i] <= '0;
            else if (reg_wr_en[WE_CORE] && v.word == ADDR)
                core_q[i] <= pwdata;
        end
    end

    always_comb begin
        core_rd = '0;
        for (int i = 0; i < CORE_WORDS; i++)
            if (v.word == W_CORE_LO + WORD_W'(i)) core_rd = core_q[i];
    end

    always_comb begin
        unique case (v.region)
            RG_ID:     mux = DIDR_VALUE;
            RG_ECR:    mux = {{(DW-ECR_W){1'b0}}, ecr_q};
            RG_CORE:   mux = core_rd;
            RG_OSSTAT: mux = {{(DW-2){1'b0}}, oslock, 1'b1};
            RG_PDCTL:  mux = {{(DW-PDCTL_W){1'b0}}, pdctl_q};
            RG_PDSTAT: mux = {{(DW-2){1'b0}}, sticky, core_pwrdn_req};
            RG_SWSTAT: mux = {{(DW-2){1'b0}}, swlock, 1'b1};
            default:   mux = '0;
        endcase
        prdata = (v.rd && !v.err) ? mux : '0;
    end

endmodule

// File: rtl/dbg_access_gate.sv
module dbg_access_gate
    import dbg_gate_pkg::*;
#(
    parameter logic [31:0] DIDR_VALUE = 32'h1510_0001,
    parameter int          ECR_W      = 8,
    parameter int          CORE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [31:0]       paddr,
    input  logic [31:0]       pwdata,
    input  logic              core_pwrdn_req,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [4:0]        reg_wr_en
);

    verdict_t v;
    logic     swlock;
    logic     oslock;
    logic     sticky;

    dbg_gate_decode u_decode (
        .psel           (psel),
        .penable        (penable),
        .pwrite         (pwrite),
        .paddr          (paddr),
        .swlock         (swlock),
        .oslock         (oslock),
        .sticky         (sticky),
        .core_pwrdn_req (core_pwrdn_req),
        .v              (v)
    );

    dbg_gate_state u_state (
        .clk            (clk),
        .rst            (rst),
        .v              (v),
        .pwdata         (pwdata),
        .core_pwrdn_req (core_pwrdn_req),
        .swlock         (swlock),
        .oslock         (oslock),
        .sticky         (sticky)
    );

    dbg_gate_regs #(
        .DIDR_VALUE (DIDR_VALUE),
        .ECR_W      (ECR_W),
        .CORE_WORDS (CORE_WORDS)
    ) u_regs (
        .clk            (clk),
        .rst            (rst),
        .v              (v),
        .pwdata         (pwdata),
        .core_pwrdn_req (core_pwrdn_req),
        .swlock         (swlock),
        .oslock         (oslock),
        .sticky         (sticky),
        .prdata         (prdata),
        .reg_wr_en      (reg_wr_en)
    );

    assign pready  = v.access;
    assign pslverr = v.err;

    // R6
    err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> (reg_wr_en == '0));

    // R6
    err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> (prdata == '0));

    // R10
    we_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_wr_en));

    // R3
    sw_lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && !paddr[31] && swlock) |-> (reg_wr_en == '0));

    // R7
    safe_region_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && paddr[11:2] == W_ECR) |-> !pslverr);

endmodule

// File: tb/dbg_access_gate_tb.sv
module dbg_access_gate_tb;

    localparam logic [31:0] KEY  = 32'hC5AC_CE55;
    localparam logic [31:0] DIDR = 32'h1510_0001;
    localparam logic [31:0] EXT  = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] paddr = '0, pwdata = '0;
    logic        core_pwrdn_req = 1'b0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [4:0]  reg_wr_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        logic [4:0]  we;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    dbg_access_gate u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .core_pwrdn_req(core_pwrdn_req),
        .prdata(prdata), .pready(pready), .pslverr(pslverr), .reg_wr_en(reg_wr_en)
    );

    // monitor: compare each access phase with the oldest expected item
    always @(negedge clk) begin
        if (!rst && psel && penable) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL unexpected transfer: actual rdata=%h expected none", prdata);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (prdata !== e.rdata || pslverr !== e.err || reg_wr_en !== e.we || pready !== 1'b1) begin
                    fails++;
                    $display("FAIL %s: actual rdata=%h err=%b we=%b rdy=%b expected rdata=%h err=%b we=%b rdy=1",
                             e.tag, prdata, pslverr, reg_wr_en, pready, e.rdata, e.err, e.we);
                end
            end
        end
    end

    task automatic xfer(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [31:0] er, input logic ee, input logic [4:0] ew,
                        input string tag);
        exp_t e;
        e.rdata = er; e.err = ee; e.we = ew; e.tag = tag;
        q.push_back(e);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] er, input logic ee, input string tag);
        xfer(1'b0, a, 32'h0, er, ee, 5'b0, tag);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic ee,
                      input logic [4:0] ew, input string tag);
        xfer(1'b1, a, d, 32'h0, ee, ew, tag);
    endtask

    task automatic set_pd(input logic val);
        @(posedge clk); #1;
        core_pwrdn_req = val;
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (pready !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle pready: actual %b expected 0", pready);
        end

        // R11 reset state, R4/R5 status layout, R7 id
        rd(32'h0000_0FB4, 32'h3, 1'b0, "R11 R4 sw lock status at reset");
        rd(32'h0000_0304, 32'h1, 1'b0, "R11 R5 os lock status at reset");
        rd(32'h0000_0314, 32'h0, 1'b0, "R11 R8 power status at reset");
        rd(32'h0000_001C, 32'h0, 1'b0, "R11 event catch at reset");
        rd(32'h0000_0000, DIDR,  1'b0, "R7 id register");

        // R3 software write dropped while locked
        wr(32'h0000_001C, 32'h5A, 1'b0, 5'b00000, "R3 locked write dropped");
        rd(32'h0000_001C, 32'h0, 1'b0, "R3 event catch unchanged");
        wr(32'h0000_0300, KEY, 1'b0, 5'b00000, "R3 locked os-key write dropped");
        rd(32'h0000_0304, 32'h1, 1'b0, "R3 os lock unchanged");

        // R2 external debugger bypasses lock
        wr(EXT | 32'h01C, 32'h5A, 1'b0, 5'b00001, "R2 R10 external write");
        rd(32'h0000_001C, 32'h5A, 1'b0, "R2 event catch written");

        // R4 unlock
        wr(32'h0000_0FB0, KEY, 1'b0, 5'b00000, "R4 unlock key");
        rd(32'h0000_0FB4, 32'h1, 1'b0, "R4 unlocked status");

        // R6 core storage accessible
        wr(32'h0000_00A4, 32'h1234, 1'b0, 5'b00100, "R10 core write enable");
        rd(32'h0000_00A4, 32'h1234, 1'b0, "R6 core read back");
        rd(32'h0000_0200, 32'h0,    1'b0, "R6 core unbacked word");

        // R5 os lock
        wr(32'h0000_0300, KEY, 1'b0, 5'b00000, "R5 os lock set");
        rd(32'h0000_0304, 32'h3, 1'b0, "R5 os lock status");
        rd(32'h0000_00A4, 32'h0, 1'b1, "R6 core read under os lock");
        wr(32'h0000_00A4, 32'hDEAD, 1'b1, 5'b00000, "R6 core write under os lock");
        rd(32'h0000_001C, 32'h5A, 1'b0, "R7 event catch under os lock");
        wr(32'h0000_0300, 32'h0, 1'b0, 5'b00000, "R5 os lock clear");
        rd(32'h0000_00A4, 32'h1234, 1'b0, "R6 discarded write");

        // R8 power down
        set_pd(1'b1);
        rd(32'h0000_00A4, 32'h0, 1'b1, "R6 core read while powered down");
        rd(32'h0000_0314, 32'h3, 1'b0, "R8 status while down");
        rd(32'h0000_0090, 32'h0, 1'b0, "R7 run control while down");
        wr(32'h0000_0310, 32'h1, 1'b0, 5'b01000, "R7 R10 power control write while down");
        rd(32'h0000_0310, 32'h1, 1'b0, "R7 power control read");
        wr(32'h0000_0F00, 32'h7, 1'b0, 5'b10000, "R10 management write");
        rd(32'h0000_0F00, 32'h0, 1'b0, "R7 management read while down");
        set_pd(1'b0);
        rd(32'h0000_00A4, 32'h0, 1'b1, "R8 sticky keeps error");
        rd(32'h0000_0314, 32'h2, 1'b0, "R8 sticky status read");
        rd(32'h0000_0314, 32'h0, 1'b0, "R8 sticky cleared");
        rd(32'h0000_00A4, 32'h1234, 1'b0, "R8 core accessible again");

        // R9 quiet read under software lock
        set_pd(1'b1);
        set_pd(1'b0);
        wr(32'h0000_0FB0, 32'h1, 1'b0, 5'b00000, "R4 relock");
        rd(32'h0000_0FB4, 32'h3, 1'b0, "R4 relocked status");
        rd(32'h0000_0314, 32'h2, 1'b0, "R9 locked status read");
        rd(32'h0000_0314, 32'h2, 1'b0, "R9 sticky kept");
        rd(EXT | 32'h314, 32'h2, 1'b0, "R9 external status read");
        rd(EXT | 32'h314, 32'h0, 1'b0, "R9 external read cleared");
        wr(32'h0000_0FB0, KEY, 1'b0, 5'b00000, "R4 key accepted while locked");
        rd(32'h0000_0FB4, 32'h1, 1'b0, "R4 unlocked again");

        // R12 unmapped
        rd(32'h0000_0800, 32'h0, 1'b0, "R12 unmapped read");
        wr(32'h0000_0800, 32'hFFFF, 1'b0, 5'b00000, "R12 unmapped write");
        rd(32'h0000_0004, 32'h0, 1'b0, "R12 unmapped low read");
        rd(32'h0000_0308, 32'h0, 1'b0, "R12 hole in power block");

        repeat (2) @(posedge clk);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R1 pending items: actual %0d expected 0", q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule